// File: doc/BRIEF.md
# One-Time-Programmable Word Array Controller

This block is a register-mapped front end for a small array of one-time-programmable words. Inside the block the array is a register file: a bit can go from 0 to 1 and never back. A processor uses a 32-bit write/read register bus. To run a command it loads a command code, a word address and a data word, sets the start bit, polls the status register until the done flag appears, and then clears start. Clearing start drops the done flag.

There are four commands: read, program-enable, program-disable and program. Programming stays locked until four program-enable commands have carried a fixed key of four values in the correct order. A separate status flag reports that programming is allowed. A program command takes longer when it sets more bits. The model for this is a base delay plus a delay per set bit. Programming ORs the data into the addressed word, so bits that are already set stay set.

Top module: `otp_word_ctrl`

## Requirements
- R1: Register offsets: control 0x00 (bit 0 = access enable), command 0x04 (6 bits), start 0x08 (bit 0), status 0x0C, read data 0x10, address 0x28 (16 bits), write data 0x2C. Upper bits written to the command and address registers read back as zero. Any unmapped offset reads zero.
- R2: While control bit 0 is 0, setting start launches no command. The done flag stays clear and the array is unchanged.
- R3: Status bit 1 (done) rises when a command finishes. It falls by the second clock edge after start has been written to 0. Status bits other than 1 and 2 read zero.
- R4: A read (code 0x0) takes READ_LAT cycles and then puts the addressed word in the read-data register. An address at or beyond DEPTH returns zero.
- R5: Four program-enable commands (code 0x2) whose data words are 0xF, 0x4, 0x8 and 0xD, in that order, set status bit 2 (programming allowed) when the fourth one finishes. The bit is not set after only three.
- R6: The sequence counter restarts from the first key value in two cases: a program-enable carries a wrong value, or any other command finishes partway through the sequence.
- R7: A program command (code 0x8) issued while locked still sets done, but it leaves the array unchanged.
- R8: A program command issued while unlocked ORs the write data into the addressed word. Bits that are already 1 stay 1.
- R9: A program command takes BASE_LAT + BIT_LAT × (number of 1 bits in the write data) cycles from launch to done. Program-enable and program-disable take 1 cycle.
- R10: Program-disable (code 0x3) clears status bit 2. After it, program commands leave the array unchanged until the full key has been sent again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset for both write and read |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr (combinational) |

## Verification
If the unlock stage counter is wrong, status bit 2 appears after the wrong key value, or never. The next status read after that command shows the error, and so does the first program command, because its read-back is either unchanged or OR-ed when it should not be. A latency counter loaded with the wrong value shows up as a launch-to-done cycle count that differs from the count the bench computes from the data's bit count. A stuck done flag shows on the status read two edges after start is cleared.

// File: rtl/otp_ctrl_pkg.sv
package otp_ctrl_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CMD_W  = 6;
  localparam int unsigned ADR_W  = 16;
  localparam int unsigned REG_AW = 8;

  typedef logic [WORD_W-1:0] word_t;

  localparam logic [CMD_W-1:0] OP_READ  = 6'h00;
  localparam logic [CMD_W-1:0] OP_ARM   = 6'h02;
  localparam logic [CMD_W-1:0] OP_DISARM = 6'h03;
  localparam logic [CMD_W-1:0] OP_PROG  = 6'h08;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_OP    = 8'h04;
  localparam logic [REG_AW-1:0] OFS_GO    = 8'h08;
  localparam logic [REG_AW-1:0] OFS_STAT  = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_RDAT  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_WADR  = 8'h28;
  localparam logic [REG_AW-1:0] OFS_WDAT  = 8'h2C;

  localparam int unsigned KEY_LEN = 4;
  localparam word_t KEY_VALS [KEY_LEN] = '{32'h0000_000F, 32'h0000_0004,
                                           32'h0000_0008, 32'h0000_000D};

  // Count of set bits in a data word.
  function automatic int unsigned ones_in(input word_t v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < int'(WORD_W); i++) n = n + {31'b0, v[i]};
    return n;
  endfunction

  // Cycles from launch to done for a given command.
  function automatic int unsigned op_cycles(input logic [CMD_W-1:0] op, input word_t d,
                                            input int unsigned base, input int unsigned per,
                                            input int unsigned rlat);
    int unsigned c;
    if (op == OP_PROG)      c = base + per * ones_in(d);
    else if (op == OP_READ) c = rlat;
    else                    c = 1;
    if (c == 0) c = 1;
    return c;
  endfunction
endpackage

// File: rtl/otp_regs.sv
module otp_regs
  import otp_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  word_t             bus_wdata,
  output word_t             bus_rdata,
  input  logic              seq_idle,
  input  logic              seq_done,
  input  logic              unlocked,
  input  word_t             rd_word,
  output logic              mode_en,
  output logic              start_q,
  output logic [CMD_W-1:0]  op_q,
  output logic [ADR_W-1:0]  adr_q,
  output word_t             wdat_q,
  output logic              launch
);
  logic wr_go;
  assign wr_go  = bus_we && (bus_addr == OFS_GO);
  assign launch = wr_go && bus_wdata[0] && !start_q && mode_en && seq_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_en <= 1'b0;
      start_q <= 1'b0;
      op_q    <= '0;
      adr_q   <= '0;
      wdat_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_CTRL: mode_en <= bus_wdata[0];
        OFS_OP:   op_q    <= bus_wdata[CMD_W-1:0];
        OFS_GO:   start_q <= bus_wdata[0];
        OFS_WADR: adr_q   <= bus_wdata[ADR_W-1:0];
        OFS_WDAT: wdat_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = {{(WORD_W-1){1'b0}}, mode_en};
      OFS_OP:   bus_rdata = {{(WORD_W-CMD_W){1'b0}}, op_q};
      OFS_GO:   bus_rdata = {{(WORD_W-1){1'b0}}, start_q};
      OFS_STAT: bus_rdata = {{(WORD_W-3){1'b0}}, unlocked, seq_done, 1'b0};
      OFS_RDAT: bus_rdata = rd_word;
      OFS_WADR: bus_rdata = {{(WORD_W-ADR_W){1'b0}}, adr_q};
      OFS_WDAT: bus_rdata = wdat_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/otp_unlock.sv
module otp_unlock
  import otp_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin,
  input  logic [CMD_W-1:0] fin_op,
  input  word_t            fin_data,
  output logic             unlocked
);
  localparam int unsigned ST_W = $clog2(KEY_LEN);
  localparam logic [ST_W-1:0] LAST = ST_W'(KEY_LEN - 1);

  logic [ST_W-1:0] stage_q;
  logic            key_hit;

  assign key_hit = (fin_data == KEY_VALS[stage_q]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      unlocked <= 1'b0;
    end else if (fin) begin
      if (fin_op == OP_DISARM) begin
        unlocked <= 1'b0;
        stage_q  <= '0;
      end else if (fin_op == OP_ARM) begin
        if (!key_hit) begin
          stage_q <= '0;
        end else if (stage_q == LAST) begin
          unlocked <= 1'b1;
          stage_q  <= '0;
        end else begin
          stage_q <= stage_q + 1'b1;
        end
      end else begin
        stage_q <= '0;
      end
    end
  end
endmodule

// File: rtl/otp_array.sv
module otp_array
  import otp_ctrl_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  word_t            set_bits,
  input  logic [IDX_W-1:0] rd_idx,
  output word_t            rd_word
);
  word_t cells [DEPTH];

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  cells[g] <= '0;
      else if (set_en && set_idx == IDX_W'(g))     cells[g] <= cells[g] | set_bits;
    end
  end

  assign rd_word = cells[rd_idx];
endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_ctrl_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned BASE_LAT = 4,
  parameter int unsigned BIT_LAT  = 1,
  parameter int unsigned READ_LAT = 2,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned MAXLAT = BASE_LAT + BIT_LAT * WORD_W + READ_LAT + 1,
  localparam int unsigned CNT_W = $clog2(MAXLAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [CMD_W-1:0] op_in,
  input  logic [ADR_W-1:0] adr_in,
  input  word_t            dat_in,
  input  logic             start_q,
  input  logic             unlocked,
  input  word_t            arr_word,
  output logic             idle,
  output logic             busy,
  output logic             done,
  output logic             fin,
  output logic [CMD_W-1:0] fin_op,
  output word_t            fin_data,
  output logic             arr_we,
  output logic [IDX_W-1:0] arr_idx,
  output word_t            rd_word
);
  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} st_t;

  st_t              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ADR_W-1:0] adr_l;
  logic             in_range;
  int unsigned      lat;

  assign idle     = (st_q == S_IDLE);
  assign busy     = (st_q == S_BUSY);
  assign done     = (st_q == S_DONE);
  assign fin      = busy && (cnt_q == '0);
  assign in_range = (adr_l < ADR_W'(DEPTH));
  assign arr_idx  = adr_l[IDX_W-1:0];
  assign arr_we   = fin && (fin_op == OP_PROG) && unlocked && in_range;
  assign lat      = op_cycles(op_in, dat_in, BASE_LAT, BIT_LAT, READ_LAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      adr_l    <= '0;
      fin_op   <= '0;
      fin_data <= '0;
      rd_word  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (launch) begin
          st_q     <= S_BUSY;
          cnt_q    <= CNT_W'(lat - 1);
          adr_l    <= adr_in;
          fin_op   <= op_in;
          fin_data <= dat_in;
        end
        S_BUSY: if (fin) begin
          st_q <= S_DONE;
          if (fin_op == OP_READ) rd_word <= in_range ? arr_word : '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        S_DONE: if (!start_q) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/otp_word_ctrl.sv
module otp_word_ctrl
  import otp_ctrl_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned BASE_LAT = 4,
  parameter int unsigned BIT_LAT  = 1,
  parameter int unsigned READ_LAT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             mode_en, start_q, launch;
  logic [CMD_W-1:0] op_q, fin_op;
  logic [ADR_W-1:0] adr_q;
  word_t            wdat_q, fin_data, arr_word, rd_word;
  logic             seq_idle, busy, done, fin, unlocked, arr_we;
  logic [IDX_W-1:0] arr_idx;

  otp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_idle(seq_idle),
    .seq_done(done), .unlocked(unlocked), .rd_word(rd_word),
    .mode_en(mode_en), .start_q(start_q), .op_q(op_q), .adr_q(adr_q),
    .wdat_q(wdat_q), .launch(launch)
  );

  otp_seq #(.DEPTH(DEPTH), .BASE_LAT(BASE_LAT), .BIT_LAT(BIT_LAT), .READ_LAT(READ_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .op_in(op_q), .adr_in(adr_q),
    .dat_in(wdat_q), .start_q(start_q), .unlocked(unlocked), .arr_word(arr_word),
    .idle(seq_idle), .busy(busy), .done(done), .fin(fin), .fin_op(fin_op),
    .fin_data(fin_data), .arr_we(arr_we), .arr_idx(arr_idx), .rd_word(rd_word)
  );

  otp_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .fin(fin), .fin_op(fin_op), .fin_data(fin_data),
    .unlocked(unlocked)
  );

  otp_array #(.DEPTH(DEPTH)) u_array (
    .clk(clk), .rst_n(rst_n), .set_en(arr_we), .set_idx(arr_idx),
    .set_bits(fin_data), .rd_idx(arr_idx), .rd_word(arr_word)
  );
endmodule

// File: rtl/otp_word_ctrl_checker.sv
module otp_word_ctrl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_en,
  input logic        start_q,
  input logic        busy,
  input logic        done,
  input logic        fin,
  input logic [5:0]  fin_op,
  input logic [31:0] fin_data,
  input logic        unlocked,
  input logic        arr_we
);
  a_r2_launch_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mode_en));

  a_r3_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_q) |=> !done);

  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r5_unlock_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(fin && fin_op == 6'h02 && fin_data == 32'hD));

  a_r7_write_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> unlocked);

  a_r10_disable_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && fin_op == 6'h03) |=> !unlocked);
endmodule

bind otp_word_ctrl otp_word_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .start_q(start_q), .busy(busy),
  .done(done), .fin(fin), .fin_op(fin_op), .fin_data(fin_data),
  .unlocked(unlocked), .arr_we(arr_we)
);

// File: tb/sim_otp_word_ctrl.sv
module sim_otp_word_ctrl;
  localparam int DEPTH = 16;
  localparam int BASE  = 4;
  localparam int PER   = 1;
  localparam int RLAT  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  int cyc_total = 0;

  otp_word_ctrl #(.DEPTH(DEPTH), .BASE_LAT(BASE), .BIT_LAT(PER), .READ_LAT(RLAT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #2 clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 100000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc_total);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic int pop(input logic [31:0] v);
    int n = 0;
    foreach (v[i]) if (v[i]) n++;
    return n;
  endfunction

  // Runs one command; returns cycles from launch to done. Checks R3 on the way.
  task automatic run_cmd(input logic [5:0] op, input logic [15:0] a, input logic [31:0] d,
                         output int cyc);
    logic [31:0] s;
    wr(8'h04, {26'b0, op});
    wr(8'h28, {16'b0, a});
    wr(8'h2C, d);
    wr(8'h08, 32'h1);
    cyc = 0;
    rd(8'h0C, s);
    while (!s[1] && cyc < 300) begin
      @(posedge clk); @(negedge clk);
      cyc++;
      rd(8'h0C, s);
    end
    chk("R3 done set", {31'b0, s[1]}, 32'h1);
    chk("R3 reserved status bits", s & 32'hFFFF_FFF9, 32'h0);
    wr(8'h08, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(8'h0C, s);
    chk("R3 done cleared after start low", {31'b0, s[1]}, 32'h0);
  endtask

  task automatic read_word(input logic [15:0] a, output logic [31:0] d, output int cyc);
    run_cmd(6'h00, a, 32'h0, cyc);
    rd(8'h10, d);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h0C, v); chk("R3 reset status", v, 32'h0);
    rd(8'h00, v); chk("R1 reset control", v, 32'h0);
    rd(8'h10, v); chk("R4 reset read data", v, 32'h0);
  endtask

  task automatic t_mode_off();
    logic [31:0] v;
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h1);
    repeat (12) @(posedge clk);
    @(negedge clk);
    rd(8'h0C, v); chk("R2 no done while access disabled", v, 32'h0);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R1 control keeps bit 0 only", v, 32'h1);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R1 command masked to 6 bits", v, 32'h3F);
    wr(8'h28, 32'h0012_3456); rd(8'h28, v); chk("R1 address masked to 16 bits", v, 32'h3456);
    wr(8'h2C, 32'hA5A5_5A5A); rd(8'h2C, v); chk("R1 write data readback", v, 32'hA5A5_5A5A);
    rd(8'h40, v); chk("R1 unmapped offset", v, 32'h0);
  endtask

  task automatic t_read_blank();
    logic [31:0] v; int c;
    read_word(16'd3, v, c);
    chk("R4 blank word", v, 32'h0);
    chk("R4 read latency", c, RLAT);
  endtask

  task automatic t_locked_prog();
    logic [31:0] v; int c;
    run_cmd(6'h08, 16'd2, 32'h0000_FFFF, c);
    read_word(16'd2, v, c);
    chk("R7 locked program leaves word", v, 32'h0);
  endtask

  task automatic unlock();
    int c;
    run_cmd(6'h02, 0, 32'hF, c);
    run_cmd(6'h02, 0, 32'h4, c);
    run_cmd(6'h02, 0, 32'h8, c);
    run_cmd(6'h02, 0, 32'hD, c);
  endtask

  task automatic t_bad_seq();
    logic [31:0] v; int c;
    run_cmd(6'h02, 0, 32'hF, c);
    chk("R9 enable latency", c, 1);
    run_cmd(6'h02, 0, 32'h4, c);
    run_cmd(6'h02, 0, 32'h7, c);
    run_cmd(6'h02, 0, 32'h8, c);
    run_cmd(6'h02, 0, 32'hD, c);
    rd(8'h0C, v); chk("R6 wrong value restarts sequence", v & 32'h4, 32'h0);
    run_cmd(6'h02, 0, 32'hF, c);
    run_cmd(6'h02, 0, 32'h4, c);
    run_cmd(6'h00, 0, 32'h0, c);
    run_cmd(6'h02, 0, 32'h8, c);
    run_cmd(6'h02, 0, 32'hD, c);
    rd(8'h0C, v); chk("R6 other command restarts sequence", v & 32'h4, 32'h0);
  endtask

  task automatic t_unlock();
    logic [31:0] v; int c;
    run_cmd(6'h02, 0, 32'hF, c);
    run_cmd(6'h02, 0, 32'h4, c);
    run_cmd(6'h02, 0, 32'h8, c);
    rd(8'h0C, v); chk("R5 not yet unlocked after three", v & 32'h4, 32'h0);
    run_cmd(6'h02, 0, 32'hD, c);
    rd(8'h0C, v); chk("R5 programming allowed after four", v & 32'h4, 32'h4);
  endtask

  task automatic t_program();
    logic [31:0] v; int c;
    run_cmd(6'h08, 16'd5, 32'h0000_00F0, c);
    chk("R9 program latency 4 bits", c, BASE + PER * pop(32'h0000_00F0));
    read_word(16'd5, v, c); chk("R8 programmed word", v, 32'h0000_00F0);
    run_cmd(6'h08, 16'd5, 32'h0000_0003, c);
    read_word(16'd5, v, c); chk("R8 OR into word", v, 32'h0000_00F3);
    run_cmd(6'h08, 16'd5, 32'h0, c);
    chk("R9 program latency zero bits", c, BASE);
    read_word(16'd5, v, c); chk("R8 bits stay set", v, 32'h0000_00F3);
    run_cmd(6'h08, 16'd15, 32'hFFFF_FFFF, c);
    chk("R9 program latency 32 bits", c, BASE + PER * 32);
    read_word(16'd15, v, c); chk("R8 last word", v, 32'hFFFF_FFFF);
    read_word(16'(DEPTH + 5), v, c); chk("R4 out of range reads zero", v, 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] v; int c;
    run_cmd(6'h03, 0, 32'h0, c);
    chk("R9 disable latency", c, 1);
    rd(8'h0C, v); chk("R10 programming flag cleared", v & 32'h4, 32'h0);
    run_cmd(6'h08, 16'd6, 32'h0000_0101, c);
    read_word(16'd6, v, c); chk("R10 program refused after disable", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode_off();
    t_regs();
    t_read_blank();
    t_locked_prog();
    t_bad_seq();
    t_unlock();
    t_program();
    t_disable();
    finish_run();
  end
endmodule